// File: doc/BRIEF.md
# Interrupt Source Sense Controller

This block is the per-source slice of a multiprocessor interrupt controller. It watches one raw interrupt line, holds that source's configuration (sense mode, mask, critical flag and priority), and keeps a pending flag that drives a request toward the priority arbiter. An acknowledge strobe from the arbiter retires the request according to the sense mode.

The block also stores the most recent raw input level, whatever the sense mode. This solves a known failure. An edge can be latched while the source is still masked and set to edge sense. If software later switches the source to level sense and the line is no longer driven, the old edge would stay pending for good and flood the processor. Here, a configuration write that leaves the source in level sense reloads pending from the stored level. The request output is then computed again from the new configuration on the same clock edge.

Top module: `irq_sense_ctrl`

## Requirements
- R1: After reset, the source is in edge sense (`sense_o`=0) and masked. Pending, the stored level, the activity bit and the request are all 0, so a later asserted input sets pending but raises no request.
- R2: In level sense (sense bit 1), every input update sets pending equal to the level being presented.
- R3: In edge sense (sense bit 0), an update with a high level sets pending. An update with a low level leaves pending unchanged. A configuration write that keeps edge sense also leaves pending unchanged.
- R4: Every input update stores the presented level in `lvl_o`, in either sense mode.
- R5: A configuration write with sense bit 1 loads pending from the stored level. If an input update happens in the same cycle, its new level is stored first and is the value loaded.
- R6: `req_o` is 1 exactly when pending is set and the source is unmasked (mask bit 1 means masked). It updates on the same clock edge as pending.
- R7: An acknowledge while in edge sense clears pending and the activity bit.
- R8: An acknowledge while in level sense changes neither pending nor the activity bit.
- R9: With the critical bit set, a pending source raises `req_o` even while masked.
- R10: The activity bit `act_o` becomes 1 on the edge after a cycle in which `req_o` was 1. It stays set until an edge-sense acknowledge clears it.
- R11: An edge-sense acknowledge that comes in the same cycle as an update with a high level leaves pending set.
- R12: `req_prio_o` shows the priority field from the most recent configuration write, one clock after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_upd_i | input | 1 | Input update strobe |
| irq_lvl_i | input | 1 | Raw line level presented with the update |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sense_i | input | 1 | Sense bit: 1 level, 0 edge |
| cfg_mask_i | input | 1 | Mask bit: 1 masked |
| cfg_crit_i | input | 1 | Critical bit: request ignores the mask |
| cfg_prio_i | input | PRIO_W | Priority field |
| ack_i | input | 1 | Acknowledge strobe from the arbiter |
| req_o | output | 1 | Request to the arbiter |
| req_prio_o | output | PRIO_W | Configured priority |
| pend_o | output | 1 | Pending flag |
| lvl_o | output | 1 | Stored raw level |
| act_o | output | 1 | Activity bit |
| sense_o | output | 1 | Current sense bit |

## Verification
Pending, the stored level, the request and the sense and priority readbacks are all due on the first rising edge after the stimulus. The activity bit follows one edge after the request it records. The bench applies each stimulus on a falling edge and compares on the next falling edge. Expected values for the activity bit therefore reflect the request seen in the row before. Rows that place an update, a configuration write and an acknowledge in the same cycle check the ordering rules at that same single-cycle point.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;
   typedef enum logic {
      SENSE_EDGE  = 1'b0,
      SENSE_LEVEL = 1'b1
   } sense_e;
endpackage

// File: rtl/irq_sense_cfg.sv
module irq_sense_cfg
   import irq_sense_pkg::*;
#(
   parameter int PRIO_W  = 4,
   parameter bit CRIT_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic              sense_i,
   input  logic              mask_i,
   input  logic              crit_i,
   input  logic [PRIO_W-1:0] prio_i,
   output sense_e            sense_q,
   output sense_e            sense_nx,
   output logic              mask_nx,
   output logic              crit_nx,
   output logic [PRIO_W-1:0] prio_q
);
   logic mask_q;
   logic crit_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sense_q <= SENSE_EDGE;
         mask_q  <= 1'b1;
         prio_q  <= '0;
      end else if (we_i) begin
         sense_q <= sense_e'(sense_i);
         mask_q  <= mask_i;
         prio_q  <= prio_i;
      end
   end

   generate
      if (CRIT_EN) begin : g_crit
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)   crit_q <= 1'b0;
            else if (we_i) crit_q <= crit_i;
         end
         assign crit_nx = we_i ? crit_i : crit_q;
      end else begin : g_nocrit
         assign crit_q  = 1'b0;
         assign crit_nx = 1'b0;
      end
   endgenerate

   assign sense_nx = we_i ? sense_e'(sense_i) : sense_q;
   assign mask_nx  = we_i ? mask_i : mask_q;
endmodule

// File: rtl/irq_sense_core.sv
module irq_sense_core
   import irq_sense_pkg::*;
(
   input  logic   clk_i,
   input  logic   rst_ni,
   input  logic   upd_i,
   input  logic   lvl_i,
   input  sense_e sense_nx,
   input  logic   ack_i,
   output logic   lvl_q,
   output logic   pend_q,
   output logic   pend_nx,
   output logic   edge_ack
);
   logic lvl_nx;

   // new level is recorded first, then used for any level-mode reload
   assign lvl_nx   = upd_i ? lvl_i : lvl_q;
   assign edge_ack = ack_i && (sense_nx == SENSE_EDGE);

   always_comb begin
      pend_nx = pend_q;
      if (sense_nx == SENSE_LEVEL) begin
         pend_nx = lvl_nx;
      end else if (upd_i && lvl_i) begin
         pend_nx = 1'b1;
      end else if (edge_ack) begin
         pend_nx = 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lvl_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         lvl_q  <= lvl_nx;
         pend_q <= pend_nx;
      end
   end
endmodule

// File: rtl/irq_sense_req.sv
module irq_sense_req (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pend_nx,
   input  logic mask_nx,
   input  logic crit_nx,
   input  logic edge_ack,
   output logic req_q,
   output logic act_q
);
   logic req_nx;

   assign req_nx = pend_nx && (!mask_nx || crit_nx);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         req_q <= 1'b0;
         act_q <= 1'b0;
      end else begin
         req_q <= req_nx;
         if (edge_ack)   act_q <= 1'b0;
         else if (req_q) act_q <= 1'b1;
      end
   end
endmodule

// File: rtl/irq_sense_ctrl.sv
module irq_sense_ctrl
   import irq_sense_pkg::*;
#(
   parameter int PRIO_W  = 4,
   parameter bit CRIT_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              irq_upd_i,
   input  logic              irq_lvl_i,
   input  logic              cfg_we_i,
   input  logic              cfg_sense_i,
   input  logic              cfg_mask_i,
   input  logic              cfg_crit_i,
   input  logic [PRIO_W-1:0] cfg_prio_i,
   input  logic              ack_i,
   output logic              req_o,
   output logic [PRIO_W-1:0] req_prio_o,
   output logic              pend_o,
   output logic              lvl_o,
   output logic              act_o,
   output logic              sense_o
);
   generate
      if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
         $error("irq_sense_ctrl: PRIO_W must be 1..8");
      end
   endgenerate

   sense_e sense_q, sense_nx;
   logic   mask_nx, crit_nx;
   logic   pend_nx, edge_ack;

   irq_sense_cfg #(.PRIO_W(PRIO_W), .CRIT_EN(CRIT_EN)) u_cfg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (cfg_we_i),
      .sense_i  (cfg_sense_i),
      .mask_i   (cfg_mask_i),
      .crit_i   (cfg_crit_i),
      .prio_i   (cfg_prio_i),
      .sense_q  (sense_q),
      .sense_nx (sense_nx),
      .mask_nx  (mask_nx),
      .crit_nx  (crit_nx),
      .prio_q   (req_prio_o)
   );

   irq_sense_core u_core (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .upd_i    (irq_upd_i),
      .lvl_i    (irq_lvl_i),
      .sense_nx (sense_nx),
      .ack_i    (ack_i),
      .lvl_q    (lvl_o),
      .pend_q   (pend_o),
      .pend_nx  (pend_nx),
      .edge_ack (edge_ack)
   );

   irq_sense_req u_req (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pend_nx  (pend_nx),
      .mask_nx  (mask_nx),
      .crit_nx  (crit_nx),
      .edge_ack (edge_ack),
      .req_q    (req_o),
      .act_q    (act_o)
   );

   assign sense_o = sense_q;
endmodule

// File: rtl/irq_sense_ctrl_chk.sv
module irq_sense_ctrl_chk #(
   parameter int PRIO_W = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              irq_upd_i,
   input logic              irq_lvl_i,
   input logic              cfg_we_i,
   input logic              cfg_sense_i,
   input logic [PRIO_W-1:0] cfg_prio_i,
   input logic              ack_i,
   input logic              req_o,
   input logic [PRIO_W-1:0] req_prio_o,
   input logic              pend_o,
   input logic              lvl_o,
   input logic              act_o,
   input logic              sense_o
);
   assert_level_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_o && !cfg_we_i && irq_upd_i) |=> (pend_o == $past(irq_lvl_i)));

   assert_edge_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sense_o && !cfg_we_i && irq_upd_i && irq_lvl_i) |=> pend_o);

   assert_edge_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sense_o && !cfg_we_i && pend_o && !ack_i) |=> pend_o);

   assert_level_record_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_upd_i |=> (lvl_o == $past(irq_lvl_i)));

   assert_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we_i && cfg_sense_i && !irq_upd_i) |=> (pend_o == $past(lvl_o)));

   assert_req_needs_pend_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_o |-> pend_o);

   assert_edge_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sense_o && !cfg_we_i && ack_i && !irq_upd_i) |=> (!pend_o && !act_o));

   assert_level_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_o && !cfg_we_i && ack_i && !irq_upd_i) |=> $stable(pend_o));

   assert_act_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o && !ack_i) |=> act_o);

   assert_prio_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_we_i |=> (req_prio_o == $past(cfg_prio_i)));
endmodule

bind irq_sense_ctrl irq_sense_ctrl_chk #(.PRIO_W(PRIO_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .irq_upd_i   (irq_upd_i),
   .irq_lvl_i   (irq_lvl_i),
   .cfg_we_i    (cfg_we_i),
   .cfg_sense_i (cfg_sense_i),
   .cfg_prio_i  (cfg_prio_i),
   .ack_i       (ack_i),
   .req_o       (req_o),
   .req_prio_o  (req_prio_o),
   .pend_o      (pend_o),
   .lvl_o       (lvl_o),
   .act_o       (act_o),
   .sense_o     (sense_o)
);

// File: tb/irq_sense_ctrl_tb_top.sv
module irq_sense_ctrl_tb_top;
   localparam int PRIO_W = 4;
   localparam int NVEC   = 16;

   // stimulus {upd, lvl, we, sense, mask, crit, ack} | expected {req, pend, lvl, act}
   localparam logic [10:0] VEC [NVEC] = '{
      11'b1100000_0110, // R3 edge, masked: high sets pending
      11'b1000000_0100, // R3 low does not clear
      11'b0011100_0000, // R5 switch to level reloads stale edge away
      11'b1100000_0110, // R2 level follows high
      11'b0011000_1110, // R6 unmask raises request
      11'b0000000_1111, // R10 activity after request
      11'b0000001_1111, // R8 level ack ignored
      11'b1000000_0001, // R2 level follows low
      11'b0010000_0001, // R3 to edge keeps pending
      11'b1100000_1111, // R3 edge sets again
      11'b0000001_0010, // R7 edge ack clears pending and activity
      11'b1100001_1110, // R11 new edge wins over ack
      11'b0010110_1111, // R9 critical ignores mask
      11'b0010100_0111, // R9 masked without critical
      11'b1011000_0001, // R5 same-cycle update low used for reload
      11'b1111000_1111  // R2 update high with write into level
   };
   localparam int TAG [NVEC] = '{3,3,5,2,6,10,8,2,3,3,7,11,9,9,5,2};

   logic              clk = 1'b0;
   logic              rst_ni;
   logic              irq_upd_i, irq_lvl_i, cfg_we_i, cfg_sense_i, cfg_mask_i, cfg_crit_i, ack_i;
   logic [PRIO_W-1:0] cfg_prio_i;
   logic              req_o, pend_o, lvl_o, act_o, sense_o;
   logic [PRIO_W-1:0] req_prio_o;
   int                checks = 0;
   int                errors = 0;
   bit                done   = 1'b0;

   always #10 clk = ~clk;

   irq_sense_ctrl #(.PRIO_W(PRIO_W)) dut_i (
      .clk_i(clk), .rst_ni(rst_ni),
      .irq_upd_i(irq_upd_i), .irq_lvl_i(irq_lvl_i),
      .cfg_we_i(cfg_we_i), .cfg_sense_i(cfg_sense_i), .cfg_mask_i(cfg_mask_i),
      .cfg_crit_i(cfg_crit_i), .cfg_prio_i(cfg_prio_i), .ack_i(ack_i),
      .req_o(req_o), .req_prio_o(req_prio_o), .pend_o(pend_o),
      .lvl_o(lvl_o), .act_o(act_o), .sense_o(sense_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle();
      irq_upd_i = 0; irq_lvl_i = 0; cfg_we_i = 0; cfg_sense_i = 0;
      cfg_mask_i = 0; cfg_crit_i = 0; ack_i = 0; cfg_prio_i = '0;
   endtask

   task automatic check_reset(input string tag);
      check({tag, " req"},   req_o,   0);
      check({tag, " pend"},  pend_o,  0);
      check({tag, " lvl"},   lvl_o,   0);
      check({tag, " act"},   act_o,   0);
      check({tag, " sense"}, sense_o, 0);
   endtask

   initial begin
      idle();
      rst_ni = 1'b0;
      repeat (3) @(negedge clk);
      rst_ni = 1'b1;
      @(negedge clk);
      check_reset("R1 reset");

      for (int i = 0; i < NVEC; i++) begin
         {irq_upd_i, irq_lvl_i, cfg_we_i, cfg_sense_i, cfg_mask_i, cfg_crit_i, ack_i} = VEC[i][10:4];
         cfg_prio_i = PRIO_W'(i);
         @(negedge clk);
         idle();
         check($sformatf("R%0d row%0d req",  TAG[i], i), req_o,  VEC[i][3]);
         check($sformatf("R%0d row%0d pend", TAG[i], i), pend_o, VEC[i][2]);
         check($sformatf("R%0d row%0d lvl",  TAG[i], i), lvl_o,  VEC[i][1]);
         check($sformatf("R%0d row%0d act",  TAG[i], i), act_o,  VEC[i][0]);
      end

      // R12: priority readback after a write
      cfg_we_i = 1; cfg_sense_i = 1; cfg_mask_i = 0; cfg_prio_i = 4'hA;
      @(negedge clk);
      idle();
      check("R12 prio", req_prio_o, 4'hA);
      check("R12 sense readback", sense_o, 1);

      // R1: mid-run reset, then masked edge source
      rst_ni = 1'b0;
      @(negedge clk);
      check_reset("R1 midrun");
      rst_ni = 1'b1;
      @(negedge clk);
      irq_upd_i = 1; irq_lvl_i = 1;
      @(negedge clk);
      idle();
      check("R1 masked no req", req_o, 0);
      check("R1 edge pend", pend_o, 1);
      check("R4 lvl recorded", lvl_o, 1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule